// File: doc/BRIEF.md
# Block lock write protection controller

This block sits in front of a 4K x 8 nonvolatile memory array. Each cycle it can take one write request, made of a 12-bit address and a data byte. It decides whether the write may go ahead. The answer is a one-cycle grant pulse or a one-cycle reject pulse, issued in the cycle after the request. The block does not store the array contents. It only decides whether the programming step downstream may run.

The protection state lives in one byte-wide register, mapped at the top address 0xFFF. A write to that address updates the register and never reaches the array. The register holds three rules that are applied in layers:

- A write-enable latch. Array writes are refused while it is clear.
- A two-bit lock span. It locks none, the top quarter, the top half or the whole of the array.
- A protect-enable bit. When it is set and the hardware write-protect pin is high, the lock span and the protect-enable bit become read-only. Together with the lock span, this turns the locked part of the array into programmable ROM.

Top module: `blk_lock_guard`

## Requirements
- R1: After reset the register reads 0x00, and `wr_grant` and `wr_reject` are low.
- R2: A request to any array address (not 0xFFF) while the write-enable latch is clear is rejected.
- R3: Register layout: bit 1 is the write-enable latch, bits 4:3 are the lock span code, bit 7 is protect-enable, and bits 0, 2, 5 and 6 always read 0. Every register write loads bit 1 from the data byte, whatever the lock state.
- R4: With the latch set and span code 00, a request to any array address is granted.
- R5: With span code 01, addresses 0xC00 to 0xFFE are rejected and addresses below 0xC00 are granted.
- R6: With span code 10, addresses 0x800 to 0xFFE are rejected and addresses below 0x800 are granted.
- R7: With span code 11, every array address is rejected.
- R8: A register write made while the latch is set, and while the pin-qualified lock is not active, is granted. It loads the span code from data bits 4:3 and protect-enable from data bit 7.
- R9: A register write made while the latch is clear is rejected, and it leaves the span code and protect-enable unchanged.
- R10: While `wp_pin` is high and protect-enable is set, a register write is rejected, and the span code and protect-enable stay unchanged.
- R11: While `wp_pin` is low, a set protect-enable bit does not block register writes.
- R12: Each request produces exactly one of `wr_grant` or `wr_reject`, for one cycle, in the cycle after the request is sampled. Neither output pulses without a request. The register reflects the write from that same cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_req | input | 1 | Write request strobe, one request per cycle it is high |
| wr_addr | input | 12 | Target address; 0xFFF selects the protection register |
| wr_data | input | 8 | Data byte of the write |
| wp_pin | input | 1 | Hardware write-protect pin, sampled with the request |
| wr_grant | output | 1 | One-cycle pulse: the write is allowed |
| wr_reject | output | 1 | One-cycle pulse: the write is refused |
| prot_reg | output | 8 | Current protection register contents |

## Verification
The assertions assume that `wr_req`, `wr_addr`, `wr_data` and `wp_pin` are synchronous to `clk` and settled at each rising edge. They also assume that address and data carry meaning only in cycles where `wr_req` is high. The bench therefore changes every input on the falling edge and holds it across the next rising edge. It keeps reset low for several cycles and waits out the two-stage reset release before the first request. Requests come both back-to-back and separated by idle cycles. The idle cycles check that no grant or reject pulse appears without a request.

// File: rtl/prot_guard_pkg.sv
package prot_guard_pkg;

  typedef enum logic [1:0] {
    SPAN_NONE    = 2'b00,
    SPAN_QUARTER = 2'b01,
    SPAN_HALF    = 2'b10,
    SPAN_ALL     = 2'b11
  } span_e;

  typedef struct packed {
    logic  pen;
    span_e span;
    logic  wel;
  } prot_state_t;

  // field positions inside the visible register byte
  localparam int unsigned WEL_POS  = 1;
  localparam int unsigned SPAN_POS = 3;
  localparam int unsigned PEN_POS  = 7;

endpackage

// File: rtl/lock_span_dec.sv
module lock_span_dec
  import prot_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  span_e             span,
  output logic              locked
);

  localparam int unsigned NSPAN = 4;

  logic [NSPAN-1:0] hit;
  logic [1:0]       sel;

  // span code g covers the top 1/4 (g=1) or 1/2 (g=2) of the space,
  // i.e. addresses whose top (3-g) bits are all ones
  generate
    for (genvar g = 0; g < NSPAN; g++) begin : g_span
      if (g == 0) begin : g_none
        assign hit[g] = 1'b0;
      end else if (g == NSPAN - 1) begin : g_all
        assign hit[g] = 1'b1;
      end else begin : g_frac
        localparam int unsigned TOPB = NSPAN - 1 - g;
        assign hit[g] = &addr[ADDR_W-1 -: TOPB];
      end
    end
  endgenerate

  assign sel    = span;
  assign locked = hit[sel];

endmodule

// File: rtl/wp_register.sv
module wp_register
  import prot_guard_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wp_pin,
  output prot_state_t       state,
  output logic              nv_ok
);

  prot_state_t state_q;
  prot_state_t state_d;
  logic        hw_lock;

  assign hw_lock = wp_pin & state_q.pen;
  assign nv_ok   = state_q.wel & ~hw_lock;

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      state_d.wel = wr_data[WEL_POS];
      if (nv_ok) begin
        state_d.span = span_e'(wr_data[SPAN_POS +: 2]);
        state_d.pen  = wr_data[PEN_POS];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (wr_en) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  // R10
  rom_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wp_pin && state_q.pen) |=> ($stable(state_q.span) && $stable(state_q.pen)));

  // R9
  no_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !state_q.wel) |=> ($stable(state_q.span) && $stable(state_q.pen)));

endmodule

// File: rtl/wr_gate.sv
module wr_gate (
  input  logic req,
  input  logic is_top,
  input  logic locked,
  input  logic wel,
  input  logic nv_ok,
  output logic grant_d,
  output logic reject_d
);

  logic allowed;

  always_comb begin
    if (is_top) begin
      allowed = nv_ok;
    end else begin
      allowed = wel & ~locked;
    end
    grant_d  = req & allowed;
    reject_d = req & ~allowed;
  end

endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard
  import prot_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wp_pin,
  output logic              wr_grant,
  output logic              wr_reject,
  output logic [DATA_W-1:0] prot_reg
);

  localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};

  // reset: asserted asynchronously, released after two clean edges
  logic rst_meta;
  logic rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  logic        is_top;
  logic        reg_wr;
  logic        locked;
  logic        nv_ok;
  logic        grant_d;
  logic        reject_d;
  logic        grant_q;
  logic        reject_q;
  prot_state_t state;

  assign is_top = (wr_addr == REG_ADDR);
  assign reg_wr = wr_req & is_top;

  wp_register #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_ok),
    .wr_en   (reg_wr),
    .wr_data (wr_data),
    .wp_pin  (wp_pin),
    .state   (state),
    .nv_ok   (nv_ok)
  );

  lock_span_dec #(.ADDR_W(ADDR_W)) u_span (
    .addr   (wr_addr),
    .span   (state.span),
    .locked (locked)
  );

  wr_gate u_gate (
    .req      (wr_req),
    .is_top   (is_top),
    .locked   (locked),
    .wel      (state.wel),
    .nv_ok    (nv_ok),
    .grant_d  (grant_d),
    .reject_d (reject_d)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      grant_q  <= grant_d;
      reject_q <= reject_d;
    end
  end

  always_comb begin
    prot_reg                  = '0;
    prot_reg[WEL_POS]         = state.wel;
    prot_reg[SPAN_POS +: 2]   = state.span;
    prot_reg[PEN_POS]         = state.pen;
  end

  assign wr_grant  = grant_q;
  assign wr_reject = reject_q;

  // R12
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(wr_grant && wr_reject));

  // R12
  outcome_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_req |=> (wr_grant || wr_reject));

  // R2
  no_latch_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_req && !state.wel) |=> !wr_grant);

  // R7
  full_span_reject_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_req && !is_top && state.span == SPAN_ALL) |=> wr_reject);

endmodule

// File: tb/blk_lock_guard_test.sv
module blk_lock_guard_test;

  logic        clk;
  logic        rst_n;
  logic        wr_req;
  logic [11:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wp_pin;
  logic        wr_grant;
  logic        wr_reject;
  logic [7:0]  prot_reg;

  blk_lock_guard uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wp_pin    (wp_pin),
    .wr_grant  (wr_grant),
    .wr_reject (wr_reject),
    .prot_reg  (prot_reg)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic       grant;
    logic       reject;
    logic [7:0] regv;
    string      tag;
  } exp_t;

  exp_t expq[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   mon_on = 0;

  // bench-side protection state, kept from the requirements
  logic       m_wel  = 0;
  logic [1:0] m_span = 0;
  logic       m_pen  = 0;

  function automatic logic [7:0] m_reg();
    return {m_pen, 2'b00, m_span, 1'b0, m_wel, 1'b0};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [7:0] d,
                    input logic wp, input string tag);
    exp_t e;
    logic ok;
    logic lk;
    @(negedge clk);
    wr_req  = 1'b1;
    wr_addr = a;
    wr_data = d;
    wp_pin  = wp;
    if (a == 12'hFFF) begin
      ok = m_wel && !(wp && m_pen);
      if (ok) begin
        m_span = d[4:3];
        m_pen  = d[7];
      end
      m_wel = d[1];
    end else begin
      case (m_span)
        2'd0: lk = 1'b0;
        2'd1: lk = (a >= 12'hC00);
        2'd2: lk = (a >= 12'h800);
        default: lk = 1'b1;
      endcase
      ok = m_wel && !lk;
    end
    e.grant  = ok;
    e.reject = !ok;
    e.regv   = m_reg();
    e.tag    = tag;
    expq.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_req = 1'b0;
    end
  endtask

  // monitor: compares each outcome one cycle after its request
  initial begin
    logic had;
    exp_t e;
    forever begin
      @(posedge clk);
      had = wr_req;
      #2;
      if (mon_on) begin
        n_chk++;
        if (had) begin
          e = expq.pop_front();
          if (wr_grant !== e.grant || wr_reject !== e.reject || prot_reg !== e.regv) begin
            n_fail++;
            $display("FAIL %s: grant/reject/reg = %b/%b/%h, expected %b/%b/%h",
                     e.tag, wr_grant, wr_reject, prot_reg, e.grant, e.reject, e.regv);
          end
        end else if (wr_grant !== 1'b0 || wr_reject !== 1'b0) begin
          n_fail++;
          $display("FAIL R12 idle: grant/reject = %b/%b, expected 0/0", wr_grant, wr_reject);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    wr_req  = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    wp_pin  = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_chk++;
    if (prot_reg !== 8'h00 || wr_grant !== 1'b0 || wr_reject !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: reg/grant/reject = %h/%b/%b, expected 00/0/0",
               prot_reg, wr_grant, wr_reject);
    end
    mon_on = 1;

    wr(12'h123, 8'h55, 1'b0, "R2 latch clear");
    idle(1);
    wr(12'hFFF, 8'hFF, 1'b0, "R9 reg write latch clear");
    wr(12'h000, 8'h11, 1'b0, "R4 span none low");
    wr(12'hFFE, 8'h22, 1'b0, "R4 span none top");
    idle(2);
    wr(12'hFFF, 8'h0A, 1'b0, "R8 set span quarter");
    wr(12'hBFF, 8'h01, 1'b0, "R5 below quarter");
    wr(12'hC00, 8'h01, 1'b0, "R5 quarter edge");
    wr(12'hFFE, 8'h01, 1'b0, "R5 quarter top");
    wr(12'hFFF, 8'h12, 1'b0, "R8 set span half");
    wr(12'h7FF, 8'h01, 1'b0, "R6 below half");
    wr(12'h800, 8'h01, 1'b0, "R6 half edge");
    wr(12'hFFF, 8'h1A, 1'b0, "R8 set span all");
    wr(12'h000, 8'h01, 1'b0, "R7 all locked");
    idle(1);
    wr(12'hFFF, 8'h82, 1'b1, "R8 set protect-enable");
    wr(12'h000, 8'h01, 1'b1, "R4 after pen");
    wr(12'hFFF, 8'h9A, 1'b1, "R10 rom mode span");
    wr(12'hFFF, 8'h00, 1'b1, "R10 R3 latch clear in rom mode");
    wr(12'h010, 8'h01, 1'b1, "R2 latch cleared");
    wr(12'hFFF, 8'h02, 1'b1, "R10 R3 latch set in rom mode");
    wr(12'hFFF, 8'h9E, 1'b0, "R11 R3 pin low unused bits");
    wr(12'hFFF, 8'h02, 1'b0, "R11 clear pen");
    idle(3);

    mon_on = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule